// File: doc/BRIEF.md
# Interrupt Mode and Vector Controller

This block sits beside the instruction sequencer of an 8-bit CPU core and decides, at each instruction boundary, whether a non-maskable or a maskable interrupt is taken and where execution continues. It keeps the two enable flip-flops, the two-bit mode state and an 8-bit vector-base register. The core drives decoded control pulses into it: enable, disable, mode select, return-from-NMI and load vector base. It also drives the data bus, which the block reads during acknowledge and when the base register is loaded.

When a request is accepted, the block registers a one-cycle acknowledge, a request to push the return address and a 16-bit target address. The core then runs the stack push and the jump. A non-maskable entry always goes to 0066h. A maskable entry goes to one of three places, chosen by the mode. In mode 0 it goes to a restart slot in page zero, decoded from a bus opcode. In mode 1 it goes to 0038h. In mode 2 it goes to an address whose high byte is the base register and whose low byte is the bus byte.

Top module: `int_vec_ctrl`

## Requirements
- R1: After reset no acknowledge is given, both enable flip-flops are 0, the mode is 0 and the vector base is 00h.
- R2: Requests are acted on only in a cycle with `boundary_i` high. The outputs `ack_o`, `push_o`, `target_o` and `bad_op_o` hold the result for exactly the following cycle and are zero otherwise.
- R3: A maskable request (`irq_i` high) is accepted only when the first enable flip-flop is 1. `ei_i` sets both enable flip-flops and `di_i` clears both. Accepting a maskable request clears both.
- R4: The rising edge of `nmi_i` is latched as pending until the next boundary. Each rising edge causes exactly one entry, and a held high level causes no further entries. The target is 0066h and `push_o` is 1.
- R5: When a non-maskable entry and a maskable request meet at the same boundary, the non-maskable one wins and the maskable one is not accepted.
- R6: A non-maskable entry copies the first enable flip-flop into the second and clears the first. A `retn_i` pulse copies the second back into the first.
- R7: When `im_set_i` is high, `im_sel_i` selects the mode: 0 gives mode 0 (state 00), 1 gives mode 1 (state 10) and 2 gives mode 2 (state 11). The value 3 leaves the mode unchanged, so the state 01 never occurs.
- R8: In mode 1 an accepted maskable request targets 0038h.
- R9: In mode 2 the target is {base, data_i}, where data_i is sampled at the boundary. A `ld_base_i` pulse loads data_i into the base register.
- R10: In mode 0 a bus byte with bits [7:6]=11 and [2:0]=111 targets {8'h00, 2'b00, bits[5:3], 3'b000}. Any other byte sets `bad_op_o`, gives target 0000h and does not assert `push_o`.
- R11: `push_o` is only ever high together with `ack_o`, and it is high on every accepted entry except a rejected mode 0 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction-boundary strobe |
| irq_i | input | 1 | Maskable request level |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| retn_i | input | 1 | Return-from-NMI pulse |
| im_set_i | input | 1 | Mode-select pulse |
| im_sel_i | input | 2 | Mode code (0, 1, 2; 3 ignored) |
| ld_base_i | input | 1 | Load vector base from data_i |
| data_i | input | 8 | Data bus |
| ack_o | output | 1 | Interrupt accepted (one cycle) |
| push_o | output | 1 | Push return address request |
| target_o | output | 16 | Jump target address |
| bad_op_o | output | 1 | Mode 0 byte not a restart opcode |

## Verification
Every result is registered once, so the outputs reflect the boundary cycle one clock later. Control pulses take effect at the edge that ends their cycle. The bench drives a boundary on a falling edge and samples the outputs on the next falling edge. It therefore reads the register written by the one rising edge in between. Whether a pending NMI or a held level causes an entry is checked at the first boundary after the stimulus. The full sweeps over bus bytes in modes 0 and 2 compute each target arithmetically.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    IM0       = 2'b00,
    IM_UNUSED = 2'b01,
    IM1       = 2'b10,
    IM2       = 2'b11
  } im_mode_e;

  localparam logic [15:0] NMI_VEC   = 16'h0066;
  localparam logic [15:0] FIXED_VEC = 16'h0038;
endpackage

// File: rtl/ivc_enable.sv
module ivc_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic retn_i,
  input  logic nmi_take_i,
  input  logic irq_take_i,
  output logic iff1_o,
  output logic iff2_o
);
  logic iff1_q, iff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (nmi_take_i) begin
      iff2_q <= iff1_q;
      iff1_q <= 1'b0;
    end else if (irq_take_i || di_i) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
    end else if (ei_i) begin
      iff1_q <= 1'b1;
      iff2_q <= 1'b1;
    end else if (retn_i) begin
      iff1_q <= iff2_q;
    end
  end

  assign iff1_o = iff1_q;
  assign iff2_o = iff2_q;

  // R6
  nmi_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_take_i |=> (!iff1_q && iff2_q == $past(iff1_q)));
  // R3
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_i && !nmi_take_i) |=> (!iff1_q && !iff2_q));
  // R3
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |-> iff1_q);
endmodule

// File: rtl/ivc_mode.sv
module ivc_mode
  import ivc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              im_set_i,
  input  logic [1:0]        im_sel_i,
  input  logic              ld_base_i,
  input  logic [DATA_W-1:0] data_i,
  output im_mode_e          mode_o,
  output logic [DATA_W-1:0] base_o
);
  im_mode_e          mode_q;
  logic [DATA_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= IM0;
    end else if (im_set_i) begin
      case (im_sel_i)
        2'd0:    mode_q <= IM0;
        2'd1:    mode_q <= IM1;
        2'd2:    mode_q <= IM2;
        default: mode_q <= mode_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (ld_base_i) base_q <= data_i;
  end

  assign mode_o = mode_q;
  assign base_o = base_q;

  // R7
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != IM_UNUSED);
  // R7
  mode_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (im_set_i && im_sel_i == 2'd3) |=> $stable(mode_q));
  // R9
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_base_i |=> base_q == $past(data_i));
endmodule

// File: rtl/ivc_target.sv
module ivc_target
  import ivc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  im_mode_e          mode_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              bad_o
);
  logic       rst_op;
  logic [2:0] slot;

  // restart opcode: 11 sss 111
  assign rst_op = (data_i[7:6] == 2'b11) && (data_i[2:0] == 3'b111);
  assign slot   = data_i[5:3];

  always_comb begin
    tgt_o = '0;
    bad_o = 1'b0;
    case (mode_i)
      IM1:     tgt_o = ADDR_W'(FIXED_VEC);
      IM2:     tgt_o = {base_i, data_i};
      default: begin
        if (rst_op) tgt_o = ADDR_W'({slot, 3'b000});
        else        bad_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/int_vec_ctrl.sv
module int_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              irq_i,
  input  logic              nmi_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              retn_i,
  input  logic              im_set_i,
  input  logic [1:0]        im_sel_i,
  input  logic              ld_base_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              bad_op_o
);
  logic nmi_q, nmi_pend_q, nmi_req, nmi_take, irq_take;
  logic iff1, iff2;
  im_mode_e          mode;
  logic [DATA_W-1:0] base;
  logic [ADDR_W-1:0] tgt;
  logic              bad;

  assign nmi_req  = nmi_pend_q | (nmi_i & ~nmi_q);
  assign nmi_take = boundary_i & nmi_req;
  assign irq_take = boundary_i & irq_i & iff1 & ~nmi_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_q <= nmi_req & ~nmi_take;
    end
  end

  ivc_enable u_enable (
    .clk_i, .rst_ni, .ei_i, .di_i, .retn_i,
    .nmi_take_i (nmi_take),
    .irq_take_i (irq_take),
    .iff1_o     (iff1),
    .iff2_o     (iff2)
  );

  ivc_mode #(.DATA_W(DATA_W)) u_mode (
    .clk_i, .rst_ni, .im_set_i, .im_sel_i, .ld_base_i, .data_i,
    .mode_o (mode),
    .base_o (base)
  );

  ivc_target #(.DATA_W(DATA_W)) u_target (
    .mode_i (mode),
    .base_i (base),
    .data_i,
    .tgt_o  (tgt),
    .bad_o  (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o    <= 1'b0;
      push_o   <= 1'b0;
      target_o <= '0;
      bad_op_o <= 1'b0;
    end else begin
      ack_o    <= nmi_take | irq_take;
      push_o   <= nmi_take | (irq_take & ~bad);
      bad_op_o <= irq_take & bad;
      if (nmi_take)      target_o <= ADDR_W'(NMI_VEC);
      else if (irq_take) target_o <= tgt;
      else               target_o <= '0;
    end
  end

  // R2
  ack_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(boundary_i));
  // R11
  push_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ack_o);
  // R5
  nmi_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && nmi_req) |=> (push_o && target_o == ADDR_W'(NMI_VEC)));
  // R6
  iff2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_take && !irq_take && !ei_i && !di_i) |=> $stable(iff2));
endmodule

// File: tb/sim_int_vec_ctrl.sv
module sim_int_vec_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, irq = 0, nmi = 0, ei = 0, di = 0, retn = 0, im_set = 0, ld_base = 0;
  logic [1:0]  im_sel = 0;
  logic [7:0]  data = 0;
  logic        ack, push, bad;
  logic [15:0] target;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  int_vec_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .irq_i(irq), .nmi_i(nmi),
    .ei_i(ei), .di_i(di), .retn_i(retn), .im_set_i(im_set), .im_sel_i(im_sel),
    .ld_base_i(ld_base), .data_i(data), .ack_o(ack), .push_o(push),
    .target_o(target), .bad_op_o(bad)
  );

  // packed result {ack, push, bad, target}
  function automatic logic [18:0] res(input logic a, p, b, input logic [15:0] t);
    return {a, p, b, t};
  endfunction

  task automatic chk(input string req, input logic [18:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic e, d, r, s, input logic [1:0] sel, input logic lb, input logic [7:0] v);
    @(negedge clk);
    ei = e; di = d; retn = r; im_set = s; im_sel = sel; ld_base = lb; data = v;
    @(negedge clk);
    ei = 0; di = 0; retn = 0; im_set = 0; ld_base = 0;
  endtask

  task automatic bnd(input logic rq, input logic [7:0] v);
    @(negedge clk);
    boundary = 1; irq = rq; data = v;
    @(negedge clk);
    boundary = 0; irq = 0;
  endtask

  function automatic logic [18:0] m0_exp(input logic [7:0] v);
    if (v[7:6] == 2'b11 && v[2:0] == 3'b111) return res(1, 1, 0, {10'd0, v[5:3], 3'd0});
    return res(1, 0, 1, 16'h0000);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset outputs and enables off
    chk("R1 outputs", res(ack, push, bad, target), res(0, 0, 0, 0));
    bnd(1, 8'hFF);
    chk("R1 irq masked", res(ack, push, bad, target), res(0, 0, 0, 0));
    // R1 mode 0 by default
    cyc(1, 0, 0, 0, 0, 0, 0);
    bnd(1, 8'hFF);
    chk("R1 mode0 default", res(ack, push, bad, target), res(1, 1, 0, 16'h0038));
    // R1 base is 00 after reset
    cyc(0, 0, 0, 1, 2'd2, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    bnd(1, 8'h9C);
    chk("R1 base zero", res(ack, push, bad, target), res(1, 1, 0, 16'h009C));

    // R2 no action without boundary
    cyc(1, 0, 0, 0, 0, 0, 0);
    @(negedge clk); irq = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 no boundary", res(ack, push, bad, target), res(0, 0, 0, 0));
    end
    irq = 0;
    // R2 result for exactly one cycle
    bnd(1, 8'h11);
    chk("R2 result", res(ack, push, bad, target), res(1, 1, 0, 16'h0011));
    @(negedge clk);
    chk("R2 one cycle", res(ack, push, bad, target), res(0, 0, 0, 0));

    // R3 disable blocks, accept clears
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    bnd(1, 8'h22);
    chk("R3 di masks", res(ack, push, bad, target), res(0, 0, 0, 0));
    cyc(1, 0, 0, 0, 0, 0, 0);
    bnd(1, 8'h22);
    chk("R3 ei accept", res(ack, push, bad, target), res(1, 1, 0, 16'h0022));
    bnd(1, 8'h22);
    chk("R3 accept clears", res(ack, push, bad, target), res(0, 0, 0, 0));

    // R7 / R8 mode 1, then code 3 keeps mode 1
    cyc(0, 0, 0, 1, 2'd1, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    bnd(1, 8'h00);
    chk("R8 mode1", res(ack, push, bad, target), res(1, 1, 0, 16'h0038));
    cyc(0, 0, 0, 1, 2'd3, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    bnd(1, 8'h47);
    chk("R7 code3 ignored", res(ack, push, bad, target), res(1, 1, 0, 16'h0038));

    // R9 mode 2 sweeps
    cyc(0, 0, 0, 1, 2'd2, 0, 0);
    for (int b = 0; b < 3; b++) begin
      logic [7:0] base;
      base = (b == 0) ? 8'h00 : (b == 1) ? 8'h5A : 8'hFF;
      cyc(0, 0, 0, 0, 0, 1, base);
      for (int v = 0; v < 256; v++) begin
        cyc(1, 0, 0, 0, 0, 0, 0);
        bnd(1, 8'(v));
        chk("R9 mode2", res(ack, push, bad, target), res(1, 1, 0, {base, 8'(v)}));
      end
    end

    // R10 / R11 mode 0 sweep
    cyc(0, 0, 0, 1, 2'd0, 0, 0);
    for (int v = 0; v < 256; v++) begin
      cyc(1, 0, 0, 0, 0, 0, 0);
      bnd(1, 8'(v));
      chk("R10 R11 mode0", res(ack, push, bad, target), m0_exp(8'(v)));
    end

    // R4 nmi pending until boundary, held level one entry
    @(negedge clk); nmi = 1;
    repeat (3) @(negedge clk);
    chk("R4 no entry before boundary", res(ack, push, bad, target), res(0, 0, 0, 0));
    bnd(0, 8'h00);
    chk("R4 nmi entry", res(ack, push, bad, target), res(1, 1, 0, 16'h0066));
    bnd(0, 8'h00);
    chk("R4 held level", res(ack, push, bad, target), res(0, 0, 0, 0));
    @(negedge clk); nmi = 0;
    // short pulse latched
    @(negedge clk); nmi = 1;
    @(negedge clk); nmi = 0;
    @(negedge clk);
    bnd(0, 8'h00);
    chk("R4 pulse latched", res(ack, push, bad, target), res(1, 1, 0, 16'h0066));

    // R5 / R6 priority and save with enabled
    cyc(1, 0, 0, 0, 0, 0, 0);
    @(negedge clk); nmi = 1;
    bnd(1, 8'hFF);
    chk("R5 nmi wins", res(ack, push, bad, target), res(1, 1, 0, 16'h0066));
    nmi = 0;
    bnd(1, 8'hFF);
    chk("R6 iff1 cleared", res(ack, push, bad, target), res(0, 0, 0, 0));
    cyc(0, 0, 1, 0, 0, 0, 0);
    bnd(1, 8'hFF);
    chk("R6 retn restores 1", res(ack, push, bad, target), res(1, 1, 0, 16'h0038));
    // R6 save with disabled
    @(negedge clk); nmi = 1;
    bnd(0, 8'h00);
    chk("R6 nmi disabled", res(ack, push, bad, target), res(1, 1, 0, 16'h0066));
    nmi = 0;
    cyc(0, 0, 1, 0, 0, 0, 0);
    bnd(1, 8'hFF);
    chk("R6 retn restores 0", res(ack, push, bad, target), res(0, 0, 0, 0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule